// File: doc/BRIEF.md
# Per-Bit Tunable Serial Frame Transmitter

This block turns queued characters into asynchronous serial frames on a single output line. Software-facing logic pushes bytes into a small transmit queue; the transmitter pulls one byte at a time and sends a start bit, 5 to 8 data bits (least significant first), an optional parity bit and one or two stop bits. Between frames the line rests high.

Bit timing comes from a programmable divisor that sets a nominal bit width of (divisor + 1) × 16 enabled UART clock cycles. The distinguishing feature is a tuning word with a 2-bit code for every frame position. Each code can stretch or compress its own bit by one sixteenth of the nominal width, so a whole frame can be shaped to meet a receiver whose clock is slightly off. A break control forces the line low, and status outputs report queue occupancy against a selectable request threshold, an empty queue, and a fully quiet transmitter.

The sequencer has five states. ST_IDLE moves to ST_START when the queue holds a byte on an enabled cycle, and pops that byte. ST_START moves to ST_DATA at the end of the start bit. ST_DATA stays until the last data bit ends, then moves to ST_PARITY if a parity bit is configured, or to ST_STOP otherwise. ST_PARITY moves to ST_STOP. ST_STOP moves to ST_IDLE after the last stop bit, or stays for a second stop bit.

Top module: `uart_ftx`

## Requirements
- R1: After reset `txd` is 1, `tx_buf_empty` is 1, `tx_idle` is 1 and `fifo_full` is 0; with no frame in progress and no break, `txd` is 1.
- R2: A frame begins with one low start bit followed by the data bits of the byte, least significant first; `cfg_data_len` values 0, 1, 2, 3 select 5, 6, 7, 8 data bits and the unused upper bits of the byte are not sent.
- R3: `cfg_two_stop` = 0 sends one high stop bit and `cfg_two_stop` = 1 sends two.
- R4: `cfg_parity` value 4 sends an odd-parity bit, 5 an even-parity bit (both computed over the sent data bits only), 6 a constant 1 bit, 7 a constant 0 bit; values 0 to 3 send no parity bit.
- R5: With tuning code 0, every bit lasts (`cfg_divisor` + 1) × 16 cycles in which `uclk_en` is 1; cycles with `uclk_en` at 0 do not advance the timing.
- R6: Frame positions are numbered from 0 (start bit) in sending order; position p takes its tuning code from `cfg_tune[2p+1:2p]`. Code 1 makes that bit (`cfg_divisor` + 1) × 17 enabled cycles long, code 3 makes it (`cfg_divisor` + 1) × 15, and codes 0 and 2 leave it at the nominal width.
- R7: While `send_break` is 1, `txd` is 0 from the next clock; frame timing keeps running underneath, so the frame resumes at its current position when the break ends.
- R8: The queue holds 16 bytes sent in push order; `fifo_full` is 1 when it holds 16, and a push while full is dropped.
- R9: `tx_req` is 1 exactly when the queue fill level is at most 0, 4, 8 or 12 for `cfg_tx_trig` values 0, 1, 2, 3.
- R10: `tx_buf_empty` is 1 when the queue holds no byte; `tx_idle` is 1 when the queue is empty and no frame is in progress.
- R11: A frame starts only on a cycle with `uclk_en` at 1, and `txd` is high for at least one clock after the last stop bit before the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uclk_en | input | 1 | UART clock enable; one timing tick per cycle where it is 1 |
| cfg_data_len | input | 2 | Data length code (0..3 for 5..8 bits) |
| cfg_two_stop | input | 1 | Stop bit count select |
| cfg_parity | input | 3 | Parity mode |
| cfg_divisor | input | 12 | Bit-rate divisor |
| cfg_tune | input | 24 | Per-position tuning codes, 2 bits each |
| cfg_tx_trig | input | 2 | Request threshold select |
| send_break | input | 1 | Force line low |
| push_valid | input | 1 | Push a byte into the queue |
| push_data | input | 8 | Byte to push |
| fifo_full | output | 1 | Queue holds 16 bytes |
| tx_buf_empty | output | 1 | Queue is empty |
| tx_idle | output | 1 | Queue empty and no frame in progress |
| tx_req | output | 1 | Fill level at or below threshold |
| txd | output | 1 | Serial output line |

## Verification
The bench measures every bit of every frame cycle by cycle from the falling start edge, so a design that counted 16 sub-steps regardless of the tuning code, looked up the code at the wrong position, or let disabled cycles advance the timing would shift a bit boundary and mismatch the line level. Alternating data patterns put an edge at every boundary so a single-cycle error in any bit is seen. Five-bit frames with bytes whose upper bits are set catch a design that sends or parities unused bits, and odd and even parity with two stop bits catch swapped parity senses or a dropped stop bit. The queue is filled while timing is frozen to probe every threshold and the full flag, and an extra push while full must not produce a seventeenth frame; a break in mid-frame must drop the line and then hand back a frame still at its old position.

// File: rtl/uft_pkg.sv
package uft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    localparam logic [2:0] PAR_ODD    = 3'd4;
    localparam logic [2:0] PAR_EVEN   = 3'd5;
    localparam logic [2:0] PAR_FORCE1 = 3'd6;
    localparam logic [2:0] PAR_FORCE0 = 3'd7;

    localparam logic [1:0] TUNE_LONG  = 2'd1;
    localparam logic [1:0] TUNE_SHORT = 2'd3;

    localparam int SUB_W = 5;

    function automatic logic [SUB_W-1:0] sub_steps(input logic [1:0] code);
        unique case (code)
            TUNE_LONG:  sub_steps = 5'd17;
            TUNE_SHORT: sub_steps = 5'd15;
            default:    sub_steps = 5'd16;
        endcase
    endfunction

    function automatic logic parity_on(input logic [2:0] mode);
        parity_on = mode[2];
    endfunction

    function automatic logic parity_value(input logic [7:0] data,
                                          input logic [1:0] len,
                                          input logic [2:0] mode);
        logic [7:0] mask;
        logic       x;
        mask = 8'hFF >> (2'd3 - len);
        x    = ^(data & mask);
        unique case (mode)
            PAR_ODD:    parity_value = ~x;
            PAR_EVEN:   parity_value = x;
            PAR_FORCE1: parity_value = 1'b1;
            default:    parity_value = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uft_fifo.sv
module uft_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_push;
    logic              do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uft_bit_timer.sv
module uft_bit_timer
    import uft_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uclk_en,
    input  logic             restart,
    input  logic             active,
    input  logic [DIV_W-1:0] divisor,
    input  logic [SUB_W-1:0] steps,
    output logic [SUB_W-1:0] sub_cnt,
    output logic             bit_done
);

    logic [DIV_W-1:0] pre_cnt;
    logic             pre_wrap;
    logic             sub_last;

    assign pre_wrap = uclk_en && active && (pre_cnt == divisor);
    assign sub_last = (sub_cnt == steps - 5'd1);
    assign bit_done = pre_wrap && sub_last && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            sub_cnt <= '0;
        end else if (restart) begin
            pre_cnt <= '0;
            sub_cnt <= '0;
        end else if (uclk_en && active) begin
            if (pre_wrap) begin
                pre_cnt <= '0;
                sub_cnt <= sub_last ? '0 : sub_cnt + 5'd1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uft_frame_fsm.sv
module uft_frame_fsm
    import uft_pkg::*;
#(
    parameter int TUNE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uclk_en,
    input  logic              fifo_empty,
    input  logic [7:0]        fifo_rdata,
    input  logic [1:0]        cfg_data_len,
    input  logic              cfg_two_stop,
    input  logic [2:0]        cfg_parity,
    input  logic [TUNE_W-1:0] cfg_tune,
    input  logic              bit_done,
    output logic              pop,
    output logic              busy,
    output logic              line_bit,
    output logic [SUB_W-1:0]  steps,
    output tx_state_e         state
);

    tx_state_e  state_q;
    tx_state_e  state_d;
    logic [7:0] shreg;
    logic [2:0] bits_left;
    logic       stops_left;
    logic [3:0] pos;
    logic       par_q;
    logic       par_en_q;
    logic       two_stop_q;
    logic       load;
    logic [1:0] code;

    assign load  = (state_q == ST_IDLE) && !fifo_empty && uclk_en;
    assign state = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) state_d = ST_START;
            end
            ST_START: begin
                if (bit_done) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_done && bits_left == 3'd0) begin
                    state_d = par_en_q ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: begin
                if (bit_done) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_done && !stops_left) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        code  = 2'(cfg_tune >> {pos, 1'b0});
        steps = sub_steps(code);
        pop   = load;
        busy  = (state_q != ST_IDLE);
        unique case (state_q)
            ST_START:  line_bit = 1'b0;
            ST_DATA:   line_bit = shreg[0];
            ST_PARITY: line_bit = par_q;
            default:   line_bit = 1'b1;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bits_left  <= '0;
            stops_left <= 1'b0;
            pos        <= '0;
            par_q      <= 1'b0;
            par_en_q   <= 1'b0;
            two_stop_q <= 1'b0;
        end else if (load) begin
            shreg      <= fifo_rdata;
            pos        <= '0;
            par_q      <= parity_value(fifo_rdata, cfg_data_len, cfg_parity);
            par_en_q   <= parity_on(cfg_parity);
            two_stop_q <= cfg_two_stop;
            bits_left  <= {1'b1, cfg_data_len};
        end else if (bit_done) begin
            pos <= pos + 4'd1;
            unique case (state_q)
                ST_DATA: begin
                    shreg     <= shreg >> 1;
                    bits_left <= bits_left - 3'd1;
                    stops_left <= two_stop_q;
                end
                ST_PARITY: stops_left <= two_stop_q;
                ST_STOP:   stops_left <= 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/uart_ftx.sv
module uart_ftx
    import uft_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DIV_W  = 12,
    parameter int TUNE_W = 24,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int TRIG_STEP = DEPTH / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uclk_en,
    input  logic [1:0]        cfg_data_len,
    input  logic              cfg_two_stop,
    input  logic [2:0]        cfg_parity,
    input  logic [DIV_W-1:0]  cfg_divisor,
    input  logic [TUNE_W-1:0] cfg_tune,
    input  logic [1:0]        cfg_tx_trig,
    input  logic              send_break,
    input  logic              push_valid,
    input  logic [7:0]        push_data,
    output logic              fifo_full,
    output logic              tx_buf_empty,
    output logic              tx_idle,
    output logic              tx_req,
    output logic              txd
);

    logic [7:0]       fifo_rdata;
    logic [CNT_W-1:0] fifo_cnt;
    logic             fifo_empty;
    logic             pop_w;
    logic             busy_w;
    logic             line_bit;
    logic [SUB_W-1:0] steps_w;
    logic [SUB_W-1:0] sub_cnt_w;
    logic             bit_done_w;
    tx_state_e        state_w;

    uft_fifo #(.DEPTH(DEPTH), .DATA_W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_valid),
        .wdata (push_data),
        .pop   (pop_w),
        .rdata (fifo_rdata),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    uft_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .uclk_en  (uclk_en),
        .restart  (pop_w),
        .active   (busy_w),
        .divisor  (cfg_divisor),
        .steps    (steps_w),
        .sub_cnt  (sub_cnt_w),
        .bit_done (bit_done_w)
    );

    uft_frame_fsm #(.TUNE_W(TUNE_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .uclk_en      (uclk_en),
        .fifo_empty   (fifo_empty),
        .fifo_rdata   (fifo_rdata),
        .cfg_data_len (cfg_data_len),
        .cfg_two_stop (cfg_two_stop),
        .cfg_parity   (cfg_parity),
        .cfg_tune     (cfg_tune),
        .bit_done     (bit_done_w),
        .pop          (pop_w),
        .busy         (busy_w),
        .line_bit     (line_bit),
        .steps        (steps_w),
        .state        (state_w)
    );

    assign tx_buf_empty = fifo_empty;
    assign tx_idle      = fifo_empty && !busy_w;
    assign tx_req       = fifo_cnt <= (CNT_W'(cfg_tx_trig) * CNT_W'(TRIG_STEP));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd <= 1'b1;
        end else begin
            txd <= send_break ? 1'b0 : line_bit;
        end
    end

endmodule

// File: rtl/uart_ftx_chk.sv
module uart_ftx_chk
    import uft_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             send_break,
    input logic             txd,
    input logic             fifo_full,
    input logic             tx_buf_empty,
    input logic             tx_idle,
    input logic             tx_req,
    input logic             pop_w,
    input logic [SUB_W-1:0] sub_cnt_w,
    input tx_state_e        state_w
);

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        send_break |=> !txd); // R7

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_IDLE && !send_break) |=> txd); // R1

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !pop_w) |=> fifo_full); // R8

    AST_REQ_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_buf_empty |-> tx_req); // R9

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> tx_buf_empty); // R10

    AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sub_cnt_w <= 5'd16); // R6

    AST_POP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        pop_w |=> (state_w == ST_START)); // R11

endmodule

bind uart_ftx uart_ftx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .send_break   (send_break),
    .txd          (txd),
    .fifo_full    (fifo_full),
    .tx_buf_empty (tx_buf_empty),
    .tx_idle      (tx_idle),
    .tx_req       (tx_req),
    .pop_w        (pop_w),
    .sub_cnt_w    (sub_cnt_w),
    .state_w      (state_w)
);

// File: tb/uart_ftx_bench.sv
`timescale 1ns/1ps
module uart_ftx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uclk_en = 1'b0;
    logic [1:0]  cfg_data_len = 2'd3;
    logic        cfg_two_stop = 1'b0;
    logic [2:0]  cfg_parity = 3'd0;
    logic [11:0] cfg_divisor = '0;
    logic [23:0] cfg_tune = '0;
    logic [1:0]  cfg_tx_trig = 2'd0;
    logic        send_break = 1'b0;
    logic        push_valid = 1'b0;
    logic [7:0]  push_data = '0;
    logic        fifo_full, tx_buf_empty, tx_idle, tx_req, txd;

    logic en_hold = 1'b1;
    logic en_half = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    logic [7:0] fbuf [16];

    always #5 clk = ~clk;

    always @(negedge clk) uclk_en <= en_hold ? 1'b0 : (en_half ? ~uclk_en : 1'b1);

    uart_ftx u_uart_ftx (
        .clk(clk), .rst_n(rst_n), .uclk_en(uclk_en),
        .cfg_data_len(cfg_data_len), .cfg_two_stop(cfg_two_stop),
        .cfg_parity(cfg_parity), .cfg_divisor(cfg_divisor),
        .cfg_tune(cfg_tune), .cfg_tx_trig(cfg_tx_trig),
        .send_break(send_break), .push_valid(push_valid),
        .push_data(push_data), .fifo_full(fifo_full),
        .tx_buf_empty(tx_buf_empty), .tx_idle(tx_idle),
        .tx_req(tx_req), .txd(txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    function automatic int exp_steps(input logic [1:0] c);
        if (c == 2'd1) return 17;
        if (c == 2'd3) return 15;
        return 16;
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input int nd, input logic [2:0] m);
        int ones = 0;
        for (int i = 0; i < nd; i++) ones += d[i];
        case (m)
            3'd4: return (ones % 2) == 0;
            3'd5: return (ones % 2) == 1;
            3'd6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = d;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    // Follow one frame on txd from its falling start edge, bit by bit.
    task automatic check_frame(input logic [7:0] d, input string tag);
        logic  lv [16];
        int    dur [16];
        string kd [16];
        int    n = 0;
        int    nd = 5 + int'(cfg_data_len);
        int    scale = (int'(cfg_divisor) + 1) * (en_half ? 2 : 1);
        lv[n] = 1'b0; kd[n] = "R2 start"; n++;
        for (int i = 0; i < nd; i++) begin lv[n] = d[i]; kd[n] = "R2 data"; n++; end
        if (cfg_parity[2]) begin lv[n] = exp_par(d, nd, cfg_parity); kd[n] = "R4 parity"; n++; end
        for (int i = 0; i < (cfg_two_stop ? 2 : 1); i++) begin lv[n] = 1'b1; kd[n] = "R3 stop"; n++; end
        for (int p = 0; p < n; p++) dur[p] = scale * exp_steps(cfg_tune[2*p +: 2]);
        while (txd !== 1'b0) @(negedge clk);
        for (int p = 0; p < n; p++) begin
            bit ok = 1;
            int bad = 0;
            for (int c = 0; c < dur[p]; c++) begin
                if (txd !== lv[p] && ok) begin ok = 0; bad = c; end
                @(negedge clk);
            end
            check(ok, {kd[p], " ", tag}, ok ? int'(lv[p]) : int'(!lv[p]), int'(lv[p]));
            if (!ok) $display("     bit %0d mismatch at cycle %0d of %0d", p, bad, dur[p]);
        end
        check(txd === 1'b1, "R11 line high after frame", int'(txd), 1);
    endtask

    task automatic run_frames(input int n, input string tag);
        fork
            begin for (int i = 0; i < n; i++) push(fbuf[i]); end
            begin for (int i = 0; i < n; i++) check_frame(fbuf[i], tag); end
        join
        repeat (3) @(negedge clk);
    endtask

    task automatic set_fmt(input logic [1:0] l, input logic [2:0] p, input logic s,
                           input logic [11:0] dv, input logic [23:0] t, input logic h);
        cfg_data_len = l; cfg_parity = p; cfg_two_stop = s;
        cfg_divisor = dv; cfg_tune = t; en_half = h;
    endtask

    initial begin
        int base;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R10 reset state
        check(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
        check(tx_buf_empty === 1'b1, "R10 empty after reset", int'(tx_buf_empty), 1);
        check(tx_idle === 1'b1, "R10 idle after reset", int'(tx_idle), 1);
        check(fifo_full === 1'b0, "R1 full after reset", int'(fifo_full), 0);

        // R8/R9 fill with timing frozen
        set_fmt(2'd3, 3'd0, 1'b0, 12'd0, 24'd0, 1'b0);
        for (int t = 0; t < 4; t++) begin
            cfg_tx_trig = 2'(t); #1;
            check(tx_req === 1'b1, "R9 req at level 0", int'(tx_req), 1);
        end
        for (int i = 0; i < 16; i++) begin
            fbuf[i] = 8'($urandom);
            push(fbuf[i]);
            #1;
            if (i == 3 || i == 4 || i == 8 || i == 12) begin
                for (int t = 0; t < 4; t++) begin
                    cfg_tx_trig = 2'(t); #1;
                    check(tx_req === ((i + 1) <= 4 * t), "R9 threshold",
                          int'(tx_req), int'((i + 1) <= 4 * t));
                end
            end
        end
        check(fifo_full === 1'b1, "R8 full at 16", int'(fifo_full), 1);
        check(tx_buf_empty === 1'b0, "R10 not empty", int'(tx_buf_empty), 0);
        check(tx_idle === 1'b0, "R10 not idle", int'(tx_idle), 0);
        cfg_tx_trig = 2'd3; #1;
        check(tx_req === 1'b0, "R9 full above 12", int'(tx_req), 0);
        push(8'hEE);
        #1;
        check(fifo_full === 1'b1, "R8 full after dropped push", int'(fifo_full), 1);
        check(txd === 1'b1, "R11 no start while enable low", int'(txd), 1);
        en_hold = 1'b0;
        for (int i = 0; i < 16; i++) check_frame(fbuf[i], "R8 order");
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1) break;
        end
        check(txd === 1'b1, "R8 dropped byte never sent", int'(txd), 1);
        check(tx_idle === 1'b1, "R10 idle after drain", int'(tx_idle), 1);

        // R2/R4/R6: 5 data bits, odd parity, two stops, all stretched; upper bits set
        set_fmt(2'd0, 3'd4, 1'b1, 12'd0, 24'h555555, 1'b0);
        fbuf[0] = 8'hF5; fbuf[1] = 8'hEA; fbuf[2] = 8'h33;
        run_frames(3, "R6 long");
        // R4 even, all compressed, half-rate enable (R5)
        set_fmt(2'd3, 3'd5, 1'b0, 12'd1, 24'hFFFFFF, 1'b1);
        fbuf[0] = 8'h55; fbuf[1] = 8'hAA; fbuf[2] = 8'h01;
        run_frames(3, "R6 short R5");
        // code 2 no effect, forced parity values
        set_fmt(2'd2, 3'd6, 1'b0, 12'd0, 24'hAAAAAA, 1'b0);
        fbuf[0] = 8'h55;
        run_frames(1, "R6 code2 R4");
        set_fmt(2'd1, 3'd7, 1'b1, 12'd2, 24'h000000, 1'b0);
        fbuf[0] = 8'h15; fbuf[1] = 8'h2A;
        run_frames(2, "R4 force0 R5");
        set_fmt(2'd3, 3'd2, 1'b0, 12'd3, 24'h0C3104, 1'b0);
        fbuf[0] = 8'h55;
        run_frames(1, "R3 R5 no parity");

        // R7 break while idle and mid-frame
        set_fmt(2'd3, 3'd0, 1'b0, 12'd0, 24'd0, 1'b0);
        @(negedge clk); send_break = 1'b1;
        @(negedge clk); @(negedge clk);
        check(txd === 1'b0, "R7 break idle", int'(txd), 0);
        send_break = 1'b0;
        @(negedge clk); @(negedge clk);
        check(txd === 1'b1, "R7 release idle", int'(txd), 1);
        push(8'hFF);
        while (txd !== 1'b0) @(negedge clk);
        base = 0;
        repeat (20) @(negedge clk);
        send_break = 1'b1;
        repeat (5) @(negedge clk);
        check(txd === 1'b0, "R7 break mid-frame", int'(txd), 0);
        check(tx_buf_empty === 1'b1, "R10 empty while sending", int'(tx_buf_empty), 1);
        check(tx_idle === 1'b0, "R10 busy while sending", int'(tx_idle), 0);
        repeat (15) @(negedge clk);
        send_break = 1'b0;
        repeat (5) @(negedge clk);
        check(txd === 1'b1, "R7 frame resumes in data", int'(txd), 1);
        repeat (105) @(negedge clk);
        check(tx_idle === 1'b0, "R7 timing kept during stop", int'(tx_idle), 0);
        repeat (15) @(negedge clk);
        check(tx_idle === 1'b1, "R7 frame ended on time", int'(tx_idle), 1);
        check(txd === 1'b1, "R1 idle high", int'(txd), 1);

        // random formats
        for (int r = 0; r < 5; r++) begin
            int nb = 1 + int'($urandom % 5);
            set_fmt(2'($urandom), 3'($urandom), 1'($urandom), 12'($urandom % 4),
                    24'($urandom), 1'($urandom));
            for (int i = 0; i < nb; i++) fbuf[i] = 8'($urandom);
            run_frames(nb, "R2 R5 R6 random");
        end
        finish_run();
    end

endmodule